// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block sits on the host side of an asynchronous, byte-wide parallel flash device. A client hands it one request at a time: an operation code, a byte address and a data byte, offered on a valid/ready handshake. The block then issues the unlock and command writes that the device expects, shaping every write strobe from clock counts. It then reads the device again and again until the embedded operation reports completion on data bit 7, and ends with a one-cycle completion or error pulse.

The three operations are single-byte program, erase of one 64 KB sector and erase of the whole device. All nanosecond limits (strobe low and high widths, the output-enable gap after a write, the read access time) are parameters. The block turns them into clock counts, always rounding up, so a slower speed grade only needs new parameter values. Each operation type has its own bound, in cycles, on how long polling may run before the block gives up and flags an error.

Top module: `flash_cmd_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. No further request is taken until `op_done` or `op_error` has been pulsed for the current one.
- R2: Op code 0 (byte program) produces exactly four bus writes in this order: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then the request data at the request address.
- R3: Op code 1 (sector erase) produces exactly six bus writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, and finally 30h at the request address. Address bits 18..16 of that address pick one of eight 64 KB sectors.
- R4: Op code 2 (chip erase) produces the same first five writes as R3. The sixth write is 10h at 5555h.
- R5: Each write holds `fl_we_n` low for at least ceil(WE_LOW_NS/clock period) cycles. During that time the address and `fl_dq_out` stay constant and `fl_dq_oe` stays high.
- R6: Between two writes of one operation, `fl_we_n` stays high for at least ceil(WE_HIGH_NS/clock period) cycles.
- R7: After the last write rises, `fl_oe_n` stays high for at least ceil(OE_HOLD_NS/clock period) cycles. `fl_dq_oe` is low whenever `fl_oe_n` is low, and `fl_we_n` and `fl_oe_n` are never low together.
- R8: Polling reads use the request address. `op_done` pulses for one cycle only after a read returns bit 7 equal to the true value: the data bit 7 for a program, 1 for either erase. It never pulses while bit 7 still reads as the complement, and a read that starts after completion ends the operation.
- R9: If polling runs PROG_TMO_CYC cycles (program) or ERASE_TMO_CYC cycles (erase) without a match, counted from the first cycle with `fl_oe_n` low, `op_error` pulses exactly that many cycles later and `op_done` does not pulse.
- R10: Op code 3 is illegal. It is answered by an `op_error` pulse on the cycle after acceptance, with no bus write and no read.
- R11: After reset, and between operations, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high and `fl_dq_oe` is low. `fl_ce_n` is low at every strobe edge of an operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 illegal |
| req_addr | input | ADDR_W | Target byte address, also used for polling |
| req_data | input | 8 | Byte to program |
| op_done | output | 1 | One-cycle pulse on successful completion |
| op_error | output | 1 | One-cycle pulse on timeout or illegal op |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_in | input | 8 | Data read from the flash (bit 7 used) |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_out` |
| fl_ce_n | output | 1 | Chip select, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
A wrong step index or op register shows up on the next strobe rising edge as a wrong address or data byte, or as a sequence that is too short or too long. The bench compares every write against a sequence it builds from the op code. A phase counter that ends early is seen within one write, as a strobe low or high width under the rounded-up minimum or as an output-enable gap that is too short. A fault in the bit 7 compare or the timeout counter shows up when the operation ends: either a completion pulse while the modelled device still reports busy, or an error whose distance from the first read differs from the configured bound.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_BAD  = 2'd3
  } fop_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WR_LO    = 3'd1,
    ST_WR_HI    = 3'd2,
    ST_POLL_RD  = 3'd3,
    ST_POLL_GAP = 3'd4,
    ST_FIN_OK   = 3'd5,
    ST_FIN_ERR  = 3'd6
  } seq_st_e;

  localparam logic [7:0]  CMD_KEY1     = 8'hAA;
  localparam logic [7:0]  CMD_KEY2     = 8'h55;
  localparam logic [7:0]  CMD_WRBYTE   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE_EN = 8'h80;
  localparam logic [7:0]  CMD_ERASE_SC = 8'h30;
  localparam logic [7:0]  CMD_ERASE_CH = 8'h10;
  localparam logic [15:0] KEY_ADDR_HI  = 16'h5555;
  localparam logic [15:0] KEY_ADDR_LO  = 16'h2AAA;

  // ceil(ns / period), never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
    int unsigned c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_cmd_table.sv
`timescale 1ns/1ps
module flash_cmd_table
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  fop_e              op_i,
  input  logic [2:0]        step_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  logic [7:0]        tgt_data_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_data_o
);

  localparam logic [ADDR_W-1:0] ADR_HI = ADDR_W'(KEY_ADDR_HI);
  localparam logic [ADDR_W-1:0] ADR_LO = ADDR_W'(KEY_ADDR_LO);

  always_comb begin
    bus_addr_o = ADR_HI;
    bus_data_o = CMD_KEY1;
    unique case (step_i)
      3'd0: begin
        bus_addr_o = ADR_HI;
        bus_data_o = CMD_KEY1;
      end
      3'd1, 3'd4: begin
        bus_addr_o = ADR_LO;
        bus_data_o = CMD_KEY2;
      end
      3'd2: begin
        bus_addr_o = ADR_HI;
        bus_data_o = (op_i == OP_PROG) ? CMD_WRBYTE : CMD_ERASE_EN;
      end
      3'd3: begin
        if (op_i == OP_PROG) begin
          bus_addr_o = tgt_addr_i;
          bus_data_o = tgt_data_i;
        end else begin
          bus_addr_o = ADR_HI;
          bus_data_o = CMD_KEY1;
        end
      end
      3'd5: begin
        if (op_i == OP_CHIP) begin
          bus_addr_o = ADR_HI;
          bus_data_o = CMD_ERASE_CH;
        end else begin
          bus_addr_o = tgt_addr_i;
          bus_data_o = CMD_ERASE_SC;
        end
      end
      default: begin
        bus_addr_o = ADR_HI;
        bus_data_o = CMD_KEY1;
      end
    endcase
  end

endmodule

// File: rtl/flash_phase_timer.sv
`timescale 1ns/1ps
module flash_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_o;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_o <= '0;
    else if (clr_i || en_i)  cnt_o <= cnt_d;
  end

  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i) |=> (cnt_o != '0)); // R9

endmodule

// File: rtl/flash_poll_watch.sv
`timescale 1ns/1ps
module flash_poll_watch
  import flash_seq_pkg::*;
#(
  parameter int                TMO_W    = 33,
  parameter longint unsigned   PROG_LIM = 64'd62_500,
  parameter longint unsigned   ERASE_LIM = 64'd7_500_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic polling_i,
  input  logic sample_i,
  input  fop_e op_i,
  input  logic data7_i,
  input  logic dq7_i,
  output logic match_o,
  output logic expire_o
);

  localparam logic [TMO_W-1:0] PROG_LAST  = TMO_W'(PROG_LIM - 1);
  localparam logic [TMO_W-1:0] ERASE_LAST = TMO_W'(ERASE_LIM - 1);

  logic [TMO_W-1:0] tmo_cnt;
  logic [TMO_W-1:0] lim_last;
  logic             exp7;

  flash_phase_timer #(.CNT_W(TMO_W)) tmo_timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (!polling_i),
    .en_i  (polling_i),
    .cnt_o (tmo_cnt)
  );

  always_comb begin
    lim_last = (op_i == OP_PROG) ? PROG_LAST : ERASE_LAST;
    exp7     = (op_i == OP_PROG) ? data7_i : 1'b1;
    match_o  = sample_i && (dq7_i == exp7);
    expire_o = polling_i && (tmo_cnt == lim_last);
  end

  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    polling_i |-> (tmo_cnt <= lim_last)); // R9

endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned     ADDR_W        = 19,
  parameter int unsigned     CLK_PS        = 4000,
  parameter int unsigned     WE_LOW_NS     = 45,
  parameter int unsigned     WE_HIGH_NS    = 20,
  parameter int unsigned     OE_HOLD_NS    = 10,
  parameter int unsigned     RD_ACC_NS     = 70,
  parameter longint unsigned PROG_TMO_CYC  = 64'd62_500,
  parameter longint unsigned ERASE_TMO_CYC = 64'd7_500_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              op_done,
  output logic              op_error,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dq_out,
  input  logic [7:0]        fl_dq_in,
  output logic              fl_dq_oe,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n
);

  localparam int unsigned LO_CYC  = ns_to_cyc(WE_LOW_NS,  CLK_PS);
  localparam int unsigned HI_CYC  = ns_to_cyc(WE_HIGH_NS, CLK_PS);
  localparam int unsigned OEH_CYC = ns_to_cyc(OE_HOLD_NS, CLK_PS);
  localparam int unsigned RD_CYC  = ns_to_cyc(RD_ACC_NS,  CLK_PS);
  localparam int unsigned GAP_CYC = umax(HI_CYC, OEH_CYC);
  localparam int unsigned PH_MAX  = umax(umax(LO_CYC, GAP_CYC), umax(RD_CYC, OEH_CYC));
  localparam int          PH_W    = $clog2(PH_MAX + 1);
  localparam longint unsigned TMO_MAX = (PROG_TMO_CYC > ERASE_TMO_CYC) ? PROG_TMO_CYC : ERASE_TMO_CYC;
  localparam int          TMO_W   = $clog2(TMO_MAX + 1);

  localparam logic [PH_W-1:0] LO_L  = PH_W'(LO_CYC - 1);
  localparam logic [PH_W-1:0] HI_L  = PH_W'(HI_CYC - 1);
  localparam logic [PH_W-1:0] GAP_L = PH_W'(GAP_CYC - 1);
  localparam logic [PH_W-1:0] OEH_L = PH_W'(OEH_CYC - 1);
  localparam logic [PH_W-1:0] RD_L  = PH_W'(RD_CYC - 1);

  // sequencer state
  seq_st_e            st_q, st_d;
  logic [2:0]         step_q, step_d;
  fop_e               op_q, op_d;
  logic [ADDR_W-1:0]  tgt_addr_q, tgt_addr_d;
  logic [7:0]         tgt_data_q, tgt_data_d;

  // timing and polling
  logic [PH_W-1:0]    ph_cnt;
  logic               in_timed;
  logic               ph_end;
  logic               polling;
  logic               sample;
  logic               match;
  logic               expire;
  logic [2:0]         last_step;

  // output next values
  logic [ADDR_W-1:0]  cmd_addr;
  logic [7:0]         cmd_data;
  logic               bus_wr_d;
  logic               bus_rd_d;
  logic               addr_en;
  logic [ADDR_W-1:0]  fl_addr_d;
  logic               dq_low_unused;

  assign dq_low_unused = ^fl_dq_in[6:0];

  always_comb begin
    in_timed  = (st_q == ST_WR_LO) || (st_q == ST_WR_HI) ||
                (st_q == ST_POLL_RD) || (st_q == ST_POLL_GAP);
    polling   = (st_q == ST_POLL_RD) || (st_q == ST_POLL_GAP);
    last_step = (op_q == OP_PROG) ? 3'd3 : 3'd5;
    ph_end    = 1'b0;
    unique case (st_q)
      ST_WR_LO:    ph_end = (ph_cnt == LO_L);
      ST_WR_HI:    ph_end = (ph_cnt == ((step_q == last_step) ? GAP_L : HI_L));
      ST_POLL_RD:  ph_end = (ph_cnt == RD_L);
      ST_POLL_GAP: ph_end = (ph_cnt == OEH_L);
      default:     ph_end = 1'b0;
    endcase
    sample = (st_q == ST_POLL_RD) && ph_end;
  end

  flash_phase_timer #(.CNT_W(PH_W)) phase_timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (ph_end || !in_timed),
    .en_i  (in_timed),
    .cnt_o (ph_cnt)
  );

  flash_poll_watch #(
    .TMO_W     (TMO_W),
    .PROG_LIM  (PROG_TMO_CYC),
    .ERASE_LIM (ERASE_TMO_CYC)
  ) poll_watch_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .polling_i (polling),
    .sample_i  (sample),
    .op_i      (op_q),
    .data7_i   (tgt_data_q[7]),
    .dq7_i     (fl_dq_in[7]),
    .match_o   (match),
    .expire_o  (expire)
  );

  // next-state logic
  always_comb begin
    st_d       = st_q;
    step_d     = step_q;
    op_d       = op_q;
    tgt_addr_d = tgt_addr_q;
    tgt_data_d = tgt_data_q;
    unique case (st_q)
      ST_IDLE: begin
        step_d = 3'd0;
        if (req_valid) begin
          op_d       = fop_e'(req_op);
          tgt_addr_d = req_addr;
          tgt_data_d = req_data;
          st_d       = (fop_e'(req_op) == OP_BAD) ? ST_FIN_ERR : ST_WR_LO;
        end
      end
      ST_WR_LO: begin
        if (ph_end) st_d = ST_WR_HI;
      end
      ST_WR_HI: begin
        if (ph_end) begin
          if (step_q == last_step) begin
            st_d = ST_POLL_RD;
          end else begin
            step_d = step_q + 3'd1;
            st_d   = ST_WR_LO;
          end
        end
      end
      ST_POLL_RD: begin
        if (match)       st_d = ST_FIN_OK;
        else if (expire) st_d = ST_FIN_ERR;
        else if (ph_end) st_d = ST_POLL_GAP;
      end
      ST_POLL_GAP: begin
        if (expire)      st_d = ST_FIN_ERR;
        else if (ph_end) st_d = ST_POLL_RD;
      end
      ST_FIN_OK, ST_FIN_ERR: st_d = ST_IDLE;
      default:               st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      step_q     <= 3'd0;
      op_q       <= OP_PROG;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      if (st_q == ST_IDLE) begin
        op_q       <= op_d;
        tgt_addr_q <= tgt_addr_d;
        tgt_data_q <= tgt_data_d;
      end
    end
  end

  // bus outputs, registered from the next state
  flash_cmd_table #(.ADDR_W(ADDR_W)) cmd_table_i (
    .op_i       (op_d),
    .step_i     (step_d),
    .tgt_addr_i (tgt_addr_d),
    .tgt_data_i (tgt_data_d),
    .bus_addr_o (cmd_addr),
    .bus_data_o (cmd_data)
  );

  always_comb begin
    bus_wr_d  = (st_d == ST_WR_LO) || (st_d == ST_WR_HI);
    bus_rd_d  = (st_d == ST_POLL_RD) || (st_d == ST_POLL_GAP);
    addr_en   = bus_wr_d || bus_rd_d;
    fl_addr_d = bus_wr_d ? cmd_addr : tgt_addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_ce_n   <= 1'b1;
      fl_we_n   <= 1'b1;
      fl_oe_n   <= 1'b1;
      fl_dq_oe  <= 1'b0;
      op_done   <= 1'b0;
      op_error  <= 1'b0;
    end else begin
      fl_ce_n   <= !addr_en;
      fl_we_n   <= (st_d != ST_WR_LO);
      fl_oe_n   <= (st_d != ST_POLL_RD);
      fl_dq_oe  <= bus_wr_d;
      op_done   <= (st_d == ST_FIN_OK);
      op_error  <= (st_d == ST_FIN_ERR);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fl_addr <= '0;
    else if (addr_en) fl_addr <= fl_addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fl_dq_out <= '0;
    else if (bus_wr_d) fl_dq_out <= cmd_data;
  end

  assign req_ready = (st_q == ST_IDLE);

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n)); // R7
  AST_READ_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe); // R7
  AST_WE_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out) && fl_dq_oe)); // R5
  AST_READY_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_we_n && fl_oe_n)); // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done); // R8
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_done && op_error)); // R9
  AST_BAD_OP_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd3) |=> (op_error && fl_ce_n)); // R10
  AST_CE_DURING_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> !fl_ce_n); // R11

endmodule

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;

  localparam int AW       = 19;
  localparam int CLK_PS   = 4000;
  localparam int WLO_NS   = 45;
  localparam int WHI_NS   = 20;
  localparam int OEH_NS   = 10;
  localparam int RDA_NS   = 70;
  localparam int PROG_LIM = 300;
  localparam int ERAS_LIM = 500;
  localparam int LO  = (WLO_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int HI  = (WHI_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int OEH = (OEH_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int RD  = (RDA_NS * 1000 + CLK_PS - 1) / CLK_PS;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_data;
  logic          op_done;
  logic          op_error;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dq_out;
  logic [7:0]    fl_dq_in;
  logic          fl_dq_oe;
  logic          fl_ce_n;
  logic          fl_we_n;
  logic          fl_oe_n;

  always #2 clk = ~clk;

  flash_cmd_seq #(
    .ADDR_W(AW), .CLK_PS(CLK_PS), .WE_LOW_NS(WLO_NS), .WE_HIGH_NS(WHI_NS),
    .OE_HOLD_NS(OEH_NS), .RD_ACC_NS(RDA_NS),
    .PROG_TMO_CYC(64'(PROG_LIM)), .ERASE_TMO_CYC(64'(ERAS_LIM))
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .op_done(op_done), .op_error(op_error), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_dq_in(fl_dq_in), .fl_dq_oe(fl_dq_oe),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  int n_tot = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit finished = 0;

  // device model state
  int            busy_left = 0;
  logic          true7 = 1'b1;
  int            arm_n = 99;
  int            arm_busy = 0;
  int            wr_n = 0;
  int            rd_n = 0;
  logic [AW-1:0] wr_a [0:7];
  logic [7:0]    wr_d [0:7];
  logic [AW-1:0] poll_addr = '0;
  int            lo_cnt = 0;
  int            hi_cnt = 0;
  logic [AW-1:0] a_fall;
  logic [7:0]    d_fall;
  bit            stab = 1;
  logic          we_p = 1'b1;
  logic          oe_p = 1'b1;
  int            oe_first = -1;
  int            t_be = -1;

  assign fl_dq_in = {(busy_left > 0) ? ~true7 : true7, 7'h2B};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tot++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] e_addr(input int op, input int i, input logic [AW-1:0] a);
    if (op == 0) return (i == 3) ? a : ((i == 1) ? AW'(16'h2AAA) : AW'(16'h5555));
    if (i == 1 || i == 4) return AW'(16'h2AAA);
    if (i == 5 && op == 1) return a;
    return AW'(16'h5555);
  endfunction

  function automatic logic [7:0] e_data(input int op, input int i, input logic [7:0] d);
    if (op == 0) begin
      case (i)
        0: return 8'hAA;
        1: return 8'h55;
        2: return 8'hA0;
        default: return d;
      endcase
    end
    case (i)
      0, 3: return 8'hAA;
      1, 4: return 8'h55;
      2: return 8'h80;
      default: return (op == 1) ? 8'h30 : 8'h10;
    endcase
  endfunction

  // bus monitor and device model
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_left > 0) begin
        busy_left = busy_left - 1;
        if (busy_left == 0) t_be = cyc;
      end
      if (we_p && !fl_we_n) begin
        if (wr_n > 0) chk(hi_cnt >= HI, "R6", "we high width", hi_cnt, HI);
        chk(!fl_ce_n, "R11", "ce at we fall", fl_ce_n, 0);
        a_fall = fl_addr;
        d_fall = fl_dq_out;
        stab = 1;
        lo_cnt = 0;
      end
      if (!we_p && fl_we_n) begin
        chk(lo_cnt >= LO, "R5", "we low width", lo_cnt, LO);
        chk(stab, "R5", "addr/data held while we low", 0, 1);
        if (wr_n < 8) begin
          wr_a[wr_n] = a_fall;
          wr_d[wr_n] = d_fall;
        end
        wr_n = wr_n + 1;
        if (wr_n == arm_n) begin
          busy_left = arm_busy;
          if (arm_busy == 0) t_be = cyc;
        end
        hi_cnt = 0;
      end
      if (oe_p && !fl_oe_n) begin
        chk(hi_cnt >= OEH, "R7", "oe gap after we", hi_cnt, OEH);
        chk(fl_addr == poll_addr, "R8", "poll address", fl_addr, poll_addr);
        if (oe_first < 0) oe_first = cyc;
        rd_n = rd_n + 1;
      end
      if (!fl_oe_n && fl_dq_oe) begin
        n_tot++;
        n_bad++;
        $display("FAIL R7 drive during read act=1 exp=0");
      end
      if (!fl_we_n) begin
        lo_cnt = lo_cnt + 1;
        if (fl_addr != a_fall || fl_dq_out != d_fall || !fl_dq_oe) stab = 0;
      end else begin
        hi_cnt = hi_cnt + 1;
      end
    end
    we_p = fl_we_n;
    oe_p = fl_oe_n;
  end

  task automatic idle_chk(input string tag);
    chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, tag, "idle bus",
        {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
    chk(req_ready, "R1", "ready when idle", req_ready, 1);
  endtask

  // kind: 0 normal, 1 timeout, 2 illegal op
  task automatic run_op(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                        input int busy, input int kind, input bit poke);
    int    k;
    int    t_acc;
    bit    got_done;
    bit    got_err;
    int    exp_n;
    string tg;
    exp_n = (op == 0) ? 4 : ((op == 3) ? 0 : 6);
    tg = (op == 0) ? "R2" : ((op == 1) ? "R3" : ((op == 2) ? "R4" : "R10"));
    busy_left = 0;
    wr_n = 0;
    rd_n = 0;
    oe_first = -1;
    t_be = -1;
    arm_n = (exp_n == 0) ? 99 : exp_n;
    arm_busy = busy;
    true7 = (op == 0) ? d[7] : 1'b1;
    poll_addr = a;
    while (!req_ready) @(negedge clk);
    req_op = 2'(op);
    req_addr = a;
    req_data = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t_acc = cyc;
    chk(!req_ready, "R1", "ready drops after accept", req_ready, 0);
    k = 0;
    while (!op_done && !op_error && k < 5000) begin
      if (poke && k >= 40 && k < 70) begin
        req_valid = 1'b1;
        req_op = 2'd1;
        chk(!req_ready, "R1", "no accept while busy", req_ready, 0);
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    req_valid = 1'b0;
    got_done = op_done;
    got_err = op_error;
    if (kind == 0) begin
      chk(got_done && !got_err, "R8", "completion", {got_done, got_err}, 2'b10);
      chk(wr_n == exp_n, tg, "write count", wr_n, exp_n);
      for (int i = 0; i < exp_n && i < wr_n; i++) begin
        chk(wr_a[i] == e_addr(op, i, a), tg, "write address", wr_a[i], e_addr(op, i, a));
        chk(wr_d[i] == e_data(op, i, d), tg, "write data", wr_d[i], e_data(op, i, d));
      end
      chk(busy_left == 0, "R8", "done while device busy", busy_left, 0);
      chk(t_be >= 0 && (cyc - t_be) <= 2 * RD + OEH + 2, "R8", "done latency",
          cyc - t_be, 2 * RD + OEH + 2);
    end else if (kind == 1) begin
      chk(got_err && !got_done, "R9", "timeout flag", {got_done, got_err}, 2'b01);
      chk((cyc - oe_first) == ((op == 0) ? PROG_LIM : ERAS_LIM), "R9", "timeout length",
          cyc - oe_first, (op == 0) ? PROG_LIM : ERAS_LIM);
    end else begin
      chk(got_err && !got_done, "R10", "illegal op flag", {got_done, got_err}, 2'b01);
      chk(cyc - t_acc == 0, "R10", "illegal op latency", cyc - t_acc, 0);
      chk(wr_n == 0 && rd_n == 0, "R10", "no bus cycles", wr_n + rd_n, 0);
    end
    @(negedge clk);
    chk(!op_done && !op_error, "R8", "flag is one pulse", {op_done, op_error}, 0);
    busy_left = 0;
    idle_chk("R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tot++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_op = 2'd0;
    req_addr = '0;
    req_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!op_done && !op_error, "R11", "flags after reset", {op_done, op_error}, 0);
    idle_chk("R11");

    // byte programs: both polarities of bit 7, several busy lengths
    for (int i = 0; i < 8; i++) begin
      run_op(0, AW'(i * 65536 + i * 4660), 8'(i * 37 + (i % 2) * 128), i * 13, 0, 0);
    end
    // sector erase across all eight sectors
    for (int s = 0; s < 8; s++) begin
      run_op(1, AW'((s << 16) | (s * 291 + 5)), 8'h00, 20 + 7 * s, 0, 0);
    end
    // chip erase, immediate and delayed completion
    run_op(2, AW'(19'h4_1234), 8'h00, 0, 0, 0);
    run_op(2, AW'(19'h7_FFFF), 8'h00, 60, 0, 0);
    // timeouts
    run_op(0, AW'(19'h3_0001), 8'h80, 1000000, 1, 0);
    run_op(1, AW'(19'h6_0ABC), 8'h00, 1000000, 1, 0);
    // illegal op code
    run_op(3, AW'(19'h1_0000), 8'h11, 0, 2, 0);
    // request offered while busy must wait
    run_op(0, AW'(19'h2_2222), 8'h7E, 150, 0, 1);
    // recovery after all of the above
    run_op(0, AW'(19'h0_0010), 8'hFF, 5, 0, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

endmodule